// File: doc/BRIEF.md
# Clipped Hardware Cursor Window

This block turns a cursor request into the rectangle the display pipeline draws. The request is a signed position, the width and height of the cursor bitmap, the active width and height of the screen, and an interlace flag. It clips the cursor against all four edges of the screen. Clipping at the left or top edge also moves the first bitmap pixel to read. In interlaced scanout the vertical values are converted to field lines.

A request that passes the size check is held in a pending set of registers. The pending set becomes the live window only at the next frame-done pulse. The live enable is set at that same pulse. Some events clear the live enable at once, without waiting for the frame boundary: a cursor that is invisible, a cursor that is absent, and a change of visible size. During scanout the block compares the raster position with the live window. It raises a hit flag and gives the bitmap word address of the pixel under the raster.

Top module: `cursor_overlay`

## Requirements
- R1: A request with `present_i`=1 whose width or height is above 64, or whose width and height are both above 32, is rejected. `reject_o` pulses for one cycle after the request cycle, and the pending and live state stay unchanged. Sizes up to 64x32 or 32x64 are accepted.
- R2: A negative X places the window at screen column 0. It shrinks the visible width by the overhang -X, down to no less than 0. It adds the overhang to the bitmap column offset.
- R3: A negative Y places the window at screen row 0. It shrinks the visible height by the overhang -Y, down to no less than 0. It adds the overhang to the bitmap row offset.
- R4: A window with X+width above `act_w_i`, or Y+height above `act_h_i`, is cut to the remaining distance to that edge. The cut size is never below 0, and it is 0 when the position lies at or beyond the edge.
- R5: With `interlace_i`=1, the screen row and the visible height are halved, with the fraction dropped. The bitmap row stride becomes twice the cursor width. The bitmap row offset is not halved.
- R6: An accepted request that has `present_i`=0, or a visible width of 0, or a visible height of 0, clears `cur_en_o` in the cycle after the request. It also drops any pending update, so a later frame-done does not set the enable.
- R7: `win_pos_o` carries the screen row in bits 31:16 and the screen column in bits 15:0. `win_size_o` carries the visible height in bits 31:16 and the visible width in bits 15:0.
- R8: An accepted, visible request changes `win_pos_o`, `win_size_o` and `cur_en_o` only at the first `frame_done_i` pulse after it. That pulse sets `cur_en_o` to 1.
- R9: When the visible size of an accepted, visible request differs from the last accepted visible size, `cur_en_o` is cleared at once. `reload_o` also pulses for one cycle. When the size is the same, neither of these happens.
- R10: `hit_o` is 1 only when all of these hold: `scan_act_i`=1, `cur_en_o`=1, the column lies in [col, col+width), and the row lies in [row, row+height) of the live window.
- R11: While `hit_o`=1, `pix_addr_o` = (row offset + raster row − window row) × stride + column offset + raster column − window column. The stride is the cursor width, or twice the width when the live request was interlaced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| upd_i | input | 1 | One-cycle request strobe |
| present_i | input | 1 | A cursor bitmap is assigned |
| pos_x_i | input | CRD_W+1 | Signed cursor column |
| pos_y_i | input | CRD_W+1 | Signed cursor row |
| width_i | input | DIM_W | Cursor bitmap width |
| height_i | input | DIM_W | Cursor bitmap height |
| act_w_i | input | CRD_W | Active screen width |
| act_h_i | input | CRD_W | Active screen height |
| interlace_i | input | 1 | Interlaced scanout |
| frame_done_i | input | 1 | Frame boundary pulse |
| scan_act_i | input | 1 | Raster is in the active area |
| scan_col_i | input | CRD_W | Raster column |
| scan_row_i | input | CRD_W | Raster row (field line when interlaced) |
| reject_o | output | 1 | Size-limit rejection pulse |
| reload_o | output | 1 | Bitmap reload request pulse |
| cur_en_o | output | 1 | Live cursor enable |
| win_pos_o | output | 32 | Live window position {row, column} |
| win_size_o | output | 32 | Live window size {height, width} |
| hit_o | output | 1 | Raster inside the live window |
| pix_addr_o | output | ADDR_W | Bitmap word address of the raster pixel |

## Verification
The clip path is exercised with a cursor fully inside the screen and with cursors that overhang each of the four edges. Each case probes a raster point whose address depends on the offset that edge creates, so a wrong offset or a wrong size shows up as a wrong address. Interlaced cases with even and odd rows, one with a top overhang, separate the halving of the row and height from the unchanged row offset and the doubled stride. Sizes at the legal corners (64x32 and 32x64) and just past them separate acceptance from rejection. Directed sequences check the timing rules: a same-size move waits for frame-done, a resize drops the enable at once, and a hidden cursor cancels a pending update.

// File: rtl/curs_ovl_pkg.sv
package curs_ovl_pkg;
  localparam int P_CRD_W  = 12;
  localparam int P_DIM_W  = 8;
  localparam int P_ADDR_W = 16;
  localparam int P_FLD_W  = 16;
  localparam int P_LONG   = 64;
  localparam int P_SHORT  = 32;

  function automatic logic [2*P_FLD_W-1:0] pack_rc(input logic [P_FLD_W-1:0] r,
                                                   input logic [P_FLD_W-1:0] c);
    return {r, c};
  endfunction
endpackage

// File: rtl/curs_axis_clip.sv
module curs_axis_clip #(
  parameter int CRD_W = 12,
  parameter int DIM_W = 8
) (
  input  logic signed [CRD_W:0] pos_i,
  input  logic [DIM_W-1:0]      len_i,
  input  logic [CRD_W-1:0]      lim_i,
  input  logic                  halve_i,
  output logic [CRD_W-1:0]      scr_o,
  output logic [DIM_W-1:0]      vis_o,
  output logic [DIM_W-1:0]      off_o
);
  localparam int EW = CRD_W + 2;

  logic signed [EW-1:0] p_s, len_s, lim_s, end_s, ovh_s, room_s;
  logic [CRD_W-1:0]     scr_raw;
  logic [DIM_W-1:0]     vis_raw;

  always_comb begin
    p_s     = {pos_i[CRD_W], pos_i};
    len_s   = $signed({{(EW-DIM_W){1'b0}}, len_i});
    lim_s   = $signed({2'b00, lim_i});
    end_s   = p_s + len_s;
    ovh_s   = -p_s;
    room_s  = lim_s - p_s;
    scr_raw = p_s[CRD_W-1:0];
    vis_raw = len_i;
    off_o   = '0;
    if (pos_i[CRD_W]) begin
      // overhang before the first pixel: shift start, shrink length
      scr_raw = '0;
      off_o   = ovh_s[DIM_W-1:0];
      vis_raw = (ovh_s >= len_s) ? '0 : DIM_W'(len_s - ovh_s);
    end else if (end_s > lim_s) begin
      // overhang past the far edge: keep what fits
      vis_raw = (!room_s[EW-1] && (room_s != '0)) ? DIM_W'(room_s) : '0;
    end
    scr_o = halve_i ? (scr_raw >> 1) : scr_raw;
    vis_o = halve_i ? (vis_raw >> 1) : vis_raw;
  end
endmodule

// File: rtl/curs_stage.sv
module curs_stage #(
  parameter int CRD_W = 12,
  parameter int DIM_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             upd_i,
  input  logic             present_i,
  input  logic             size_ok_i,
  input  logic             frame_done_i,
  input  logic [CRD_W-1:0] xs_i,
  input  logic [CRD_W-1:0] ys_i,
  input  logic [DIM_W-1:0] vw_i,
  input  logic [DIM_W-1:0] vh_i,
  input  logic [DIM_W-1:0] xoff_i,
  input  logic [DIM_W-1:0] yoff_i,
  input  logic [DIM_W:0]   stride_i,
  output logic             en_o,
  output logic [CRD_W-1:0] xs_o,
  output logic [CRD_W-1:0] ys_o,
  output logic [DIM_W-1:0] w_o,
  output logic [DIM_W-1:0] h_o,
  output logic [DIM_W-1:0] xoff_o,
  output logic [DIM_W-1:0] yoff_o,
  output logic [DIM_W:0]   stride_o,
  output logic             reject_o,
  output logic             reload_o
);
  // pending set
  logic             pv_q;
  logic [CRD_W-1:0] p_xs_q, p_ys_q;
  logic [DIM_W-1:0] p_w_q, p_h_q, p_xoff_q, p_yoff_q;
  logic [DIM_W:0]   p_str_q;
  // live set
  logic             en_q;
  logic [CRD_W-1:0] c_xs_q, c_ys_q;
  logic [DIM_W-1:0] c_w_q, c_h_q, c_xoff_q, c_yoff_q;
  logic [DIM_W:0]   c_str_q;
  // last accepted visible size
  logic [DIM_W-1:0] l_w_q, l_h_q;
  logic             rej_q, rld_q;

  logic rej_d, acc, hidden, kill, take, resize;
  logic pend_ld, com_ld, last_ld, pv_d, en_d;

  always_comb begin
    rej_d   = upd_i && present_i && !size_ok_i;
    acc     = upd_i && !rej_d;
    hidden  = !present_i || (vw_i == '0) || (vh_i == '0);
    kill    = acc && hidden;
    take    = acc && !hidden;
    resize  = take && ({vh_i, vw_i} != {l_h_q, l_w_q});
    pend_ld = take;
    last_ld = resize;
    com_ld  = !upd_i && frame_done_i && pv_q;
    pv_d    = pv_q;
    if (take)                pv_d = 1'b1;
    else if (kill || com_ld) pv_d = 1'b0;
    en_d    = en_q;
    if (kill || resize)      en_d = 1'b0;
    else if (com_ld)         en_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pv_q <= 1'b0; en_q <= 1'b0; rej_q <= 1'b0; rld_q <= 1'b0;
      p_xs_q <= '0; p_ys_q <= '0; p_w_q <= '0; p_h_q <= '0;
      p_xoff_q <= '0; p_yoff_q <= '0; p_str_q <= '0;
      c_xs_q <= '0; c_ys_q <= '0; c_w_q <= '0; c_h_q <= '0;
      c_xoff_q <= '0; c_yoff_q <= '0; c_str_q <= '0;
      l_w_q <= '0; l_h_q <= '0;
    end else begin
      pv_q  <= pv_d;
      en_q  <= en_d;
      rej_q <= rej_d;
      rld_q <= resize;
      if (pend_ld) begin
        p_xs_q <= xs_i; p_ys_q <= ys_i; p_w_q <= vw_i; p_h_q <= vh_i;
        p_xoff_q <= xoff_i; p_yoff_q <= yoff_i; p_str_q <= stride_i;
      end
      if (com_ld) begin
        c_xs_q <= p_xs_q; c_ys_q <= p_ys_q; c_w_q <= p_w_q; c_h_q <= p_h_q;
        c_xoff_q <= p_xoff_q; c_yoff_q <= p_yoff_q; c_str_q <= p_str_q;
      end
      if (last_ld) begin
        l_w_q <= vw_i; l_h_q <= vh_i;
      end
    end
  end

  assign en_o     = en_q;
  assign xs_o     = c_xs_q;
  assign ys_o     = c_ys_q;
  assign w_o      = c_w_q;
  assign h_o      = c_h_q;
  assign xoff_o   = c_xoff_q;
  assign yoff_o   = c_yoff_q;
  assign stride_o = c_str_q;
  assign reject_o = rej_q;
  assign reload_o = rld_q;

  assert_reject_holds_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_i && present_i && !size_ok_i) |=> $stable(en_q) && $stable(pv_q) && $stable(c_w_q) && $stable(c_xs_q));
  assert_commit_at_frame_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en_q) |-> $past(frame_done_i) && $past(pv_q));
  assert_live_visible_R6: assert property (@(posedge clk) disable iff (!rst_n)
    en_q |-> (c_w_q != '0) && (c_h_q != '0));
  assert_hidden_drops_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_i && !present_i) |=> !en_q && !pv_q);
  assert_reload_blanks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rld_q |-> !en_q);
endmodule

// File: rtl/curs_scan.sv
module curs_scan #(
  parameter int CRD_W  = 12,
  parameter int DIM_W  = 8,
  parameter int ADDR_W = 16
) (
  input  logic              en_i,
  input  logic              act_i,
  input  logic [CRD_W-1:0]  col_i,
  input  logic [CRD_W-1:0]  row_i,
  input  logic [CRD_W-1:0]  xs_i,
  input  logic [CRD_W-1:0]  ys_i,
  input  logic [DIM_W-1:0]  w_i,
  input  logic [DIM_W-1:0]  h_i,
  input  logic [DIM_W-1:0]  xoff_i,
  input  logic [DIM_W-1:0]  yoff_i,
  input  logic [DIM_W:0]    stride_i,
  output logic              hit_o,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int CW = CRD_W + 1;

  logic [CW-1:0]     col_e, row_e, xs_e, ys_e, xe, ye, dcw, drw;
  logic              in_x, in_y;
  logic [ADDR_W-1:0] line_a, addr_a;

  always_comb begin
    col_e  = {1'b0, col_i};
    row_e  = {1'b0, row_i};
    xs_e   = {1'b0, xs_i};
    ys_e   = {1'b0, ys_i};
    xe     = xs_e + {{(CW-DIM_W){1'b0}}, w_i};
    ye     = ys_e + {{(CW-DIM_W){1'b0}}, h_i};
    in_x   = (col_e >= xs_e) && (col_e < xe);
    in_y   = (row_e >= ys_e) && (row_e < ye);
    hit_o  = act_i && en_i && in_x && in_y;
    dcw    = col_e - xs_e;
    drw    = row_e - ys_e;
    line_a = ADDR_W'(yoff_i) + ADDR_W'(drw[DIM_W-1:0]);
    addr_a = line_a * ADDR_W'(stride_i) + ADDR_W'(xoff_i) + ADDR_W'(dcw[DIM_W-1:0]);
    addr_o = hit_o ? addr_a : '0;
  end
endmodule

// File: rtl/cursor_overlay.sv
module cursor_overlay #(
  parameter int CRD_W  = curs_ovl_pkg::P_CRD_W,
  parameter int DIM_W  = curs_ovl_pkg::P_DIM_W,
  parameter int ADDR_W = curs_ovl_pkg::P_ADDR_W,
  parameter int LONG   = curs_ovl_pkg::P_LONG,
  parameter int SHORT  = curs_ovl_pkg::P_SHORT
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    upd_i,
  input  logic                    present_i,
  input  logic signed [CRD_W:0]   pos_x_i,
  input  logic signed [CRD_W:0]   pos_y_i,
  input  logic [DIM_W-1:0]        width_i,
  input  logic [DIM_W-1:0]        height_i,
  input  logic [CRD_W-1:0]        act_w_i,
  input  logic [CRD_W-1:0]        act_h_i,
  input  logic                    interlace_i,
  input  logic                    frame_done_i,
  input  logic                    scan_act_i,
  input  logic [CRD_W-1:0]        scan_col_i,
  input  logic [CRD_W-1:0]        scan_row_i,
  output logic                    reject_o,
  output logic                    reload_o,
  output logic                    cur_en_o,
  output logic [31:0]             win_pos_o,
  output logic [31:0]             win_size_o,
  output logic                    hit_o,
  output logic [ADDR_W-1:0]       pix_addr_o
);
  localparam int FW = curs_ovl_pkg::P_FLD_W;
  localparam int NAX = 2;  // 0: column axis, 1: row axis

  logic signed [CRD_W:0] ax_pos [NAX];
  logic [DIM_W-1:0]      ax_len [NAX];
  logic [CRD_W-1:0]      ax_lim [NAX];
  logic [CRD_W-1:0]      ax_scr [NAX];
  logic [DIM_W-1:0]      ax_vis [NAX];
  logic [DIM_W-1:0]      ax_off [NAX];

  assign ax_pos[0] = pos_x_i;  assign ax_pos[1] = pos_y_i;
  assign ax_len[0] = width_i;  assign ax_len[1] = height_i;
  assign ax_lim[0] = act_w_i;  assign ax_lim[1] = act_h_i;

  for (genvar a = 0; a < NAX; a++) begin : g_axis
    logic halve;
    if (a == 1) begin : g_row
      assign halve = interlace_i;
    end else begin : g_col
      assign halve = 1'b0;
    end
    curs_axis_clip #(.CRD_W(CRD_W), .DIM_W(DIM_W)) i_clip (
      .pos_i(ax_pos[a]), .len_i(ax_len[a]), .lim_i(ax_lim[a]), .halve_i(halve),
      .scr_o(ax_scr[a]), .vis_o(ax_vis[a]), .off_o(ax_off[a]));
  end

  logic           size_ok;
  logic [DIM_W:0] stride;

  always_comb begin
    size_ok = !((32'(width_i) > LONG) || (32'(height_i) > LONG) ||
                ((32'(width_i) > SHORT) && (32'(height_i) > SHORT)));
    stride  = interlace_i ? {width_i, 1'b0} : {1'b0, width_i};
  end

  logic [CRD_W-1:0] l_xs, l_ys;
  logic [DIM_W-1:0] l_w, l_h, l_xoff, l_yoff;
  logic [DIM_W:0]   l_str;

  curs_stage #(.CRD_W(CRD_W), .DIM_W(DIM_W)) i_stage (
    .clk(clk), .rst_n(rst_n), .upd_i(upd_i), .present_i(present_i),
    .size_ok_i(size_ok), .frame_done_i(frame_done_i),
    .xs_i(ax_scr[0]), .ys_i(ax_scr[1]), .vw_i(ax_vis[0]), .vh_i(ax_vis[1]),
    .xoff_i(ax_off[0]), .yoff_i(ax_off[1]), .stride_i(stride),
    .en_o(cur_en_o), .xs_o(l_xs), .ys_o(l_ys), .w_o(l_w), .h_o(l_h),
    .xoff_o(l_xoff), .yoff_o(l_yoff), .stride_o(l_str),
    .reject_o(reject_o), .reload_o(reload_o));

  curs_scan #(.CRD_W(CRD_W), .DIM_W(DIM_W), .ADDR_W(ADDR_W)) i_scan (
    .en_i(cur_en_o), .act_i(scan_act_i), .col_i(scan_col_i), .row_i(scan_row_i),
    .xs_i(l_xs), .ys_i(l_ys), .w_i(l_w), .h_i(l_h), .xoff_i(l_xoff),
    .yoff_i(l_yoff), .stride_i(l_str), .hit_o(hit_o), .addr_o(pix_addr_o));

  assign win_pos_o  = curs_ovl_pkg::pack_rc(FW'(l_ys), FW'(l_xs));
  assign win_size_o = curs_ovl_pkg::pack_rc(FW'(l_h), FW'(l_w));

  assert_hit_needs_enable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    hit_o |-> cur_en_o && scan_act_i);
  assert_hit_in_columns_R10: assert property (@(posedge clk) disable iff (!rst_n)
    hit_o |-> (FW'(scan_col_i) >= win_pos_o[15:0]) && (FW'(scan_col_i) < win_pos_o[15:0] + win_size_o[15:0]));
  assert_reject_not_reload_R1: assert property (@(posedge clk) disable iff (!rst_n)
    reject_o |-> !reload_o);
endmodule

// File: tb/test_cursor_overlay.sv
`timescale 1ns/1ps
module test_cursor_overlay;
  typedef struct packed {
    logic        pres;
    logic [12:0] x;
    logic [12:0] y;
    logic [7:0]  w;
    logic [7:0]  h;
    logic        il;
    logic [11:0] col;
    logic [11:0] row;
    logic        rej;
    logic        en;
    logic [31:0] pos;
    logic [31:0] sz;
    logic        hit;
    logic [15:0] addr;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t TBL [NV] = '{
    '{1'b1, 13'(100), 13'(50),  8'd32, 8'd32, 1'b0, 12'd110, 12'd60,  1'b0, 1'b1, {16'd50, 16'd100},  {16'd32, 16'd32}, 1'b1, 16'd330},
    '{1'b1, 13'(-5),  13'(20),  8'd16, 8'd8,  1'b0, 12'd0,   12'd20,  1'b0, 1'b1, {16'd20, 16'd0},    {16'd8, 16'd11},  1'b1, 16'd5},
    '{1'b1, 13'(30),  13'(-3),  8'd10, 8'd8,  1'b0, 12'd39,  12'd4,   1'b0, 1'b1, {16'd0, 16'd30},    {16'd5, 16'd10},  1'b1, 16'd79},
    '{1'b1, 13'(630), 13'(470), 8'd20, 8'd16, 1'b0, 12'd639, 12'd479, 1'b0, 1'b1, {16'd470, 16'd630}, {16'd10, 16'd10}, 1'b1, 16'd189},
    '{1'b1, 13'(200), 13'(100), 8'd8,  8'd8,  1'b0, 12'd208, 12'd100, 1'b0, 1'b1, {16'd100, 16'd200}, {16'd8, 16'd8},   1'b0, 16'd0},
    '{1'b1, 13'(40),  13'(101), 8'd16, 8'd16, 1'b1, 12'd41,  12'd52,  1'b0, 1'b1, {16'd50, 16'd40},   {16'd8, 16'd16},  1'b1, 16'd65},
    '{1'b1, 13'(0),   13'(-4),  8'd16, 8'd12, 1'b1, 12'd3,   12'd1,   1'b0, 1'b1, {16'd0, 16'd0},     {16'd4, 16'd16},  1'b1, 16'd163},
    '{1'b1, 13'(0),   13'(0),   8'd65, 8'd10, 1'b1, 12'd3,   12'd1,   1'b1, 1'b1, {16'd0, 16'd0},     {16'd4, 16'd16},  1'b1, 16'd163},
    '{1'b1, 13'(0),   13'(0),   8'd40, 8'd40, 1'b0, 12'd3,   12'd1,   1'b1, 1'b1, {16'd0, 16'd0},     {16'd4, 16'd16},  1'b1, 16'd163},
    '{1'b1, 13'(10),  13'(10),  8'd64, 8'd32, 1'b0, 12'd73,  12'd41,  1'b0, 1'b1, {16'd10, 16'd10},   {16'd32, 16'd64}, 1'b1, 16'd2047},
    '{1'b1, 13'(0),   13'(0),   8'd32, 8'd64, 1'b0, 12'd31,  12'd63,  1'b0, 1'b1, {16'd0, 16'd0},     {16'd64, 16'd32}, 1'b1, 16'd2047},
    '{1'b1, 13'(-40), 13'(5),   8'd32, 8'd8,  1'b0, 12'd0,   12'd5,   1'b0, 1'b0, {16'd0, 16'd0},     {16'd64, 16'd32}, 1'b0, 16'd0},
    '{1'b1, 13'(5),   13'(5),   8'd8,  8'd8,  1'b0, 12'd5,   12'd5,   1'b0, 1'b1, {16'd5, 16'd5},     {16'd8, 16'd8},   1'b1, 16'd0},
    '{1'b0, 13'(5),   13'(5),   8'd8,  8'd8,  1'b0, 12'd5,   12'd5,   1'b0, 1'b0, {16'd5, 16'd5},     {16'd8, 16'd8},   1'b0, 16'd0},
    '{1'b1, 13'(0),   13'(480), 8'd8,  8'd8,  1'b0, 12'd0,   12'd480, 1'b0, 1'b0, {16'd5, 16'd5},     {16'd8, 16'd8},   1'b0, 16'd0}
  };

  logic clk = 1'b0;
  logic rst_n;
  logic upd, present, il, fd, sact;
  logic signed [12:0] px, py;
  logic [7:0]  cw, ch;
  logic [11:0] aw, ah, scol, srow;
  logic        reject, reload, en, hit;
  logic [31:0] wpos, wsize;
  logic [15:0] addr;
  int nchk = 0;
  int nfail = 0;
  logic done = 1'b0;

  always #4 clk = ~clk;

  cursor_overlay i_cursor_overlay (
    .clk(clk), .rst_n(rst_n), .upd_i(upd), .present_i(present),
    .pos_x_i(px), .pos_y_i(py), .width_i(cw), .height_i(ch),
    .act_w_i(aw), .act_h_i(ah), .interlace_i(il), .frame_done_i(fd),
    .scan_act_i(sact), .scan_col_i(scol), .scan_row_i(srow),
    .reject_o(reject), .reload_o(reload), .cur_en_o(en),
    .win_pos_o(wpos), .win_size_o(wsize), .hit_o(hit), .pix_addr_o(addr));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic send(input logic p, input logic [12:0] x, input logic [12:0] y,
                      input logic [7:0] w, input logic [7:0] h, input logic i);
    @(negedge clk);
    present = p; px = $signed(x); py = $signed(y); cw = w; ch = h; il = i; upd = 1'b1;
    @(negedge clk);
    upd = 1'b0;
  endtask

  task automatic frame();
    @(negedge clk); fd = 1'b1;
    @(negedge clk); fd = 0;
  endtask

  task automatic probe(input logic [11:0] c, input logic [11:0] r, input logic a);
    scol = c; srow = r; sact = a;
    #1;
  endtask

  function automatic string vtag(input int i);
    case (i)
      1: return "R2";
      2: return "R3";
      3, 14: return "R4";
      4: return "R10";
      5, 6: return "R5";
      7, 8, 9, 10: return "R1";
      11, 13: return "R6";
      12: return "R11";
      default: return "R7";
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL R8 watchdog: actual=running expected=finished");
      $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; upd = 0; present = 0; il = 0; fd = 0; sact = 0;
    px = '0; py = '0; cw = '0; ch = '0; aw = 12'd640; ah = 12'd480; scol = '0; srow = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    // reset state
    chk("R8 reset en", 32'(en), 32'd0);
    chk("R7 reset pos", wpos, 32'd0);
    chk("R7 reset size", wsize, 32'd0);
    chk("R1 reset reject", 32'(reject), 32'd0);
    chk("R9 reset reload", 32'(reload), 32'd0);
    chk("R10 reset hit", 32'(hit), 32'd0);

    for (int i = 0; i < NV; i++) begin
      send(TBL[i].pres, TBL[i].x, TBL[i].y, TBL[i].w, TBL[i].h, TBL[i].il);
      #1;
      chk($sformatf("R1 reject v%0d", i), 32'(reject), 32'(TBL[i].rej));
      frame();
      probe(TBL[i].col, TBL[i].row, 1'b1);
      chk($sformatf("%s en v%0d", vtag(i), i), 32'(en), 32'(TBL[i].en));
      chk($sformatf("%s R7 pos v%0d", vtag(i), i), wpos, TBL[i].pos);
      chk($sformatf("%s R7 size v%0d", vtag(i), i), wsize, TBL[i].sz);
      chk($sformatf("%s R10 hit v%0d", vtag(i), i), 32'(hit), 32'(TBL[i].hit));
      if (TBL[i].hit)
        chk($sformatf("%s R11 addr v%0d", vtag(i), i), 32'(addr), 32'(TBL[i].addr));
      sact = 1'b0;
    end

    // same size as the last accepted one: no reload, waits for frame-done
    send(1'b1, 13'(20), 13'(30), 8'd8, 8'd8, 1'b0);
    #1;
    chk("R9 same size no reload", 32'(reload), 32'd0);
    chk("R8 not yet enabled", 32'(en), 32'd0);
    frame(); #1;
    chk("R8 enabled at frame", 32'(en), 32'd1);
    chk("R8 pos at frame", wpos, {16'd30, 16'd20});

    // move: held until the frame boundary
    send(1'b1, 13'(50), 13'(60), 8'd8, 8'd8, 1'b0);
    repeat (5) @(negedge clk);
    #1;
    chk("R8 pos held", wpos, {16'd30, 16'd20});
    chk("R8 en held", 32'(en), 32'd1);
    frame(); #1;
    chk("R8 pos moved", wpos, {16'd60, 16'd50});

    // resize: immediate blank plus one reload pulse
    send(1'b1, 13'(50), 13'(60), 8'd16, 8'd8, 1'b0);
    #1;
    chk("R9 reload pulse", 32'(reload), 32'd1);
    chk("R9 blank at once", 32'(en), 32'd0);
    @(negedge clk); #1;
    chk("R9 reload single", 32'(reload), 32'd0);
    frame(); #1;
    chk("R9 enabled after frame", 32'(en), 32'd1);
    chk("R9 new size", wsize, {16'd8, 16'd16});

    // scan gating
    probe(12'd50, 12'd60, 1'b0);
    chk("R10 idle raster", 32'(hit), 32'd0);
    probe(12'd50, 12'd60, 1'b1);
    chk("R10 active raster", 32'(hit), 32'd1);
    chk("R11 first pixel", 32'(addr), 32'd0);
    probe(12'd65, 12'd67, 1'b1);
    chk("R11 last pixel", 32'(addr), 32'd127);
    probe(12'd66, 12'd67, 1'b1);
    chk("R10 right of window", 32'(hit), 32'd0);
    sact = 1'b0;

    // off the right edge: visible width 0, immediate disable
    send(1'b1, 13'(700), 13'(10), 8'd16, 8'd8, 1'b0);
    #1;
    chk("R6 off-screen blank", 32'(en), 32'd0);
    chk("R4 off-screen not rejected", 32'(reject), 32'd0);

    // pending update cancelled by a hidden request
    send(1'b1, 13'(1), 13'(2), 8'd16, 8'd8, 1'b0);
    send(1'b0, 13'(1), 13'(2), 8'd16, 8'd8, 1'b0);
    frame(); #1;
    chk("R6 pending dropped", 32'(en), 32'd0);
    chk("R6 pos untouched", wpos, {16'd60, 16'd50});

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule